// File: doc/BRIEF.md
# Writer-Priority Reader-Writer Lock Arbiter

This block shares one parent lock among a single writer channel and a group of reader channels. Every channel uses a four-phase request/acknowledge handshake, and so does the parent lock. When the wait condition holds, the block raises its lock request. Once the grant arrives, it runs one lock cycle. In that cycle the writer is served on its own, and the readers are served as a bundle with all their acknowledges raised together. The block lowers the lock request only after every handshake of the cycle has closed.

A channel that is not requesting when its turn comes is passed over. A request that rises after its turn has gone waits for the next lock cycle. Two parameters change the behaviour. The first swaps the order so that the reader bundle goes before the writer. The second tightens the wait condition so that the lock is requested only when the writer asks, or when every reader asks at once. All behaviour is synchronous to one clock. Reset is asynchronous and active-low.

Top module: `rw_lock_arb`

## Requirements
- R1: With the default wait condition, the lock request rises one cycle after any of the writer or readers is seen requesting while the block is idle.
- R2: In the default order, the writer acknowledge rises first and falls again before any reader acknowledge rises.
- R3: Every reader that is requesting when the reader turn begins is acknowledged in the same cycle as the other selected readers. Each reader acknowledge falls one cycle after its own request falls.
- R4: With READER_FIRST=1, the reader bundle is served and fully released before the writer acknowledge rises.
- R5: With PAIR_WAIT=1, the lock is requested only while the writer requests or all readers request together. A lone reader request leaves the lock request low.
- R6: A channel that is not requesting at its turn is skipped and never acknowledged in that lock cycle, and the cycle continues to the next turn.
- R7: The lock request falls only after every acknowledge of the cycle is low. No acknowledge is high unless the lock request is high.
- R8: The writer acknowledge and any reader acknowledge are never high in the same cycle.
- R9: A request that rises after its channel's turn has passed is not served in the current lock cycle. It is served in a following lock cycle, which needs a new rise of the lock request.
- R10: While reset is low, every acknowledge and the lock request are low, whatever the state of the handshakes before reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Writer request |
| wr_ack | output | 1 | Writer acknowledge |
| rd_req | input | NRD | Reader requests, one bit per reader |
| rd_ack | output | NRD | Reader acknowledges, one bit per reader |
| lock_req | output | 1 | Request to the parent lock |
| lock_gnt | input | 1 | Grant from the parent lock |

## Verification
The bench covers every mix of writer and reader requests on two instances at once. One instance uses the default order and wait condition. The other serves readers first and waits for a full reader pair. A design that served readers before the writer, or that split the reader bundle across cycles, would put its acknowledge rises in the wrong order on the scoreboard. A late writer request raised during the reader turn must cost a second lock cycle, so a design that slipped it into the current cycle would show too few lock rises. A lone reader under the pair condition must leave the lock untouched, and a reset during an open writer handshake must clear every output at once.

// File: rtl/rw_lock_arb.sv
module rw_lock_arb #(
  parameter bit READER_FIRST = 1'b0,
  parameter bit PAIR_WAIT    = 1'b0,
  parameter int NRD          = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_req,
  output logic           wr_ack,
  input  logic [NRD-1:0] rd_req,
  output logic [NRD-1:0] rd_ack,
  output logic           lock_req,
  input  logic           lock_gnt
);

  typedef enum logic [2:0] {
    S_IDLE, S_LOCK, S_WR, S_WHOLD, S_RD, S_RHOLD, S_REL
  } st_t;

  localparam st_t FIRST    = READER_FIRST ? S_RD  : S_WR;
  localparam st_t AFTER_WR = READER_FIRST ? S_REL : S_RD;
  localparam st_t AFTER_RD = READER_FIRST ? S_WR  : S_REL;

  st_t            st, st_n;
  logic           wr_ack_n;
  logic [NRD-1:0] rd_ack_n;
  logic           wants;

  assign wants = PAIR_WAIT ? (wr_req | (&rd_req)) : (wr_req | (|rd_req));

  always_comb begin
    st_n     = st;
    wr_ack_n = wr_ack;
    rd_ack_n = rd_ack;
    case (st)
      S_IDLE:  if (wants) st_n = S_LOCK;
      S_LOCK:  if (lock_gnt) st_n = FIRST;
      S_WR: begin
        if (wr_req) begin
          wr_ack_n = 1'b1;
          st_n     = S_WHOLD;
        end else begin
          st_n = AFTER_WR;
        end
      end
      S_WHOLD: begin
        if (!wr_req) begin
          wr_ack_n = 1'b0;
          st_n     = AFTER_WR;
        end
      end
      S_RD: begin
        if (|rd_req) begin
          rd_ack_n = rd_req;
          st_n     = S_RHOLD;
        end else begin
          st_n = AFTER_RD;
        end
      end
      S_RHOLD: begin
        rd_ack_n = rd_ack & rd_req;
        if (rd_ack_n == '0) st_n = AFTER_RD;
      end
      S_REL:   if (!lock_gnt) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wr_ack   <= 1'b0;
      rd_ack   <= '0;
      lock_req <= 1'b0;
    end else begin
      st       <= st_n;
      wr_ack   <= wr_ack_n;
      rd_ack   <= rd_ack_n;
      lock_req <= (st_n != S_IDLE) && (st_n != S_REL);
    end
  end

endmodule

// File: rtl/rw_lock_arb_chk.sv
module rw_lock_arb_chk #(
  parameter bit READER_FIRST = 1'b0,
  parameter bit PAIR_WAIT    = 1'b0,
  parameter int NRD          = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_req,
  input logic           wr_ack,
  input logic [NRD-1:0] rd_req,
  input logic [NRD-1:0] rd_ack,
  input logic           lock_req,
  input logic           lock_gnt
);

  logic wanted;
  assign wanted = PAIR_WAIT ? (wr_req | (&rd_req)) : (wr_req | (|rd_req));

  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ack && (|rd_ack))); // R8
  AST_LOCK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_req) |-> $past(wanted)); // R5
  AST_ACK_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack || (|rd_ack)) |-> lock_req); // R7
  AST_REL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_req) |-> (!wr_ack && rd_ack == '0)); // R7
  AST_WR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_ack) |-> $past(wr_req)); // R6
  AST_WR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && wr_req) |=> wr_ack); // R2
  AST_RD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_ack & ~$past(rd_ack)) != '0) |-> ((rd_ack & ~$past(rd_req)) == '0)); // R3

endmodule

bind rw_lock_arb rw_lock_arb_chk #(
  .READER_FIRST(READER_FIRST), .PAIR_WAIT(PAIR_WAIT), .NRD(NRD)
) u_chk (.*);

// File: tb/rw_lock_arb_tb.sv
module rw_lock_arb_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       wq[2], wa[2], lq[2], lg[2];
  logic [1:0] rq[2], ra[2];
  int nchk = 0, nerr = 0;
  int lrise[2];
  logic [2:0] exp0[$], exp1[$];
  string tag0[$], tag1[$];
  bit done = 0;

  rw_lock_arb #(.READER_FIRST(1'b0), .PAIR_WAIT(1'b0), .NRD(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_req(wq[0]), .wr_ack(wa[0]),
    .rd_req(rq[0]), .rd_ack(ra[0]), .lock_req(lq[0]), .lock_gnt(lg[0]));
  rw_lock_arb #(.READER_FIRST(1'b1), .PAIR_WAIT(1'b1), .NRD(2)) u_dut_rp (
    .clk(clk), .rst_n(rst_n), .wr_req(wq[1]), .wr_ack(wa[1]),
    .rd_req(rq[1]), .rd_ack(ra[1]), .lock_req(lq[1]), .lock_gnt(lg[1]));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // requesters and parent lock model
  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (wq[d] && wa[d]) wq[d] <= 1'b0;
      for (int b = 0; b < 2; b++)
        if (rq[d][b] && ra[d][b]) rq[d][b] <= 1'b0;
      lg[d] <= lq[d] & rst_n;
    end
  end

  // monitor / scoreboard
  logic pwa[2], plq[2];
  logic [1:0] pra[2];
  initial begin
    for (int d = 0; d < 2; d++) begin
      pwa[d] = 0; pra[d] = 0; plq[d] = 0; lrise[d] = 0;
    end
  end
  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (rst_n) begin
        logic [2:0] got, e;
        string t;
        got = {wa[d], ra[d]};
        if ((wa[d] && !pwa[d]) || ((ra[d] & ~pra[d]) != 0)) begin
          if (d == 0 && exp0.size() > 0) begin e = exp0.pop_front(); t = tag0.pop_front(); end
          else if (d == 1 && exp1.size() > 0) begin e = exp1.pop_front(); t = tag1.pop_front(); end
          else begin e = 3'b000; t = "R6 unexpected ack"; end
          check(got == e, t, got, e);
        end
        if (wa[d] && ra[d] != 0) check(1'b0, "R8 exclusion", got, 0);
        if (lq[d] && !plq[d]) lrise[d]++;
        if (!lq[d] && plq[d]) check(got == 0, "R7 release after acks", got, 0);
      end
      pwa[d] = wa[d]; pra[d] = ra[d]; plq[d] = lq[d];
    end
  end

  task automatic wait_idle();
    int n = 0;
    int quiet = 0;
    while (quiet < 4 && n < 600) begin
      @(negedge clk);
      n++;
      if (!wq[0] && !wq[1] && rq[0] == 0 && rq[1] == 0 && !wa[0] && !wa[1] &&
          ra[0] == 0 && ra[1] == 0 && !lq[0] && !lq[1] && !lg[0] && !lg[1]) quiet++;
      else quiet = 0;
    end
    check(n < 600, "R7 lock cycle completes", n, 0);
    check(exp0.size() == 0 && exp1.size() == 0, "R6 all expected acks seen",
          exp0.size() + exp1.size(), 0);
  endtask

  task automatic scen(input bit w, input bit r0, input bit r1);
    bit c0, c1;
    int l0;
    c0 = w | r0 | r1;
    c1 = w | (r0 & r1);
    if (w)       begin exp0.push_back(3'b100); tag0.push_back("R2 writer first"); end
    if (r0 | r1) begin exp0.push_back({1'b0, r1, r0}); tag0.push_back("R3 readers bundled"); end
    if (c1) begin
      if (r0 | r1) begin exp1.push_back({1'b0, r1, r0}); tag1.push_back("R4 readers first"); end
      if (w)       begin exp1.push_back(3'b100); tag1.push_back("R4 writer after readers"); end
    end
    l0 = lrise[0];
    @(negedge clk);
    wq[0] <= w; rq[0] <= {r1, r0};
    wq[1] <= w; rq[1] <= {r1, r0};
    if (!c1) begin
      repeat (30) @(negedge clk);
      check(lq[1] == 1'b0 && wa[1] == 1'b0 && ra[1] == 0, "R5 pair wait holds lock", lq[1], 0);
      wq[1] <= 1'b0; rq[1] <= 2'b00;
    end
    wait_idle();
    check(lrise[0] - l0 == int'(c0), "R1 lock requested on any request", lrise[0] - l0, int'(c0));
  endtask

  initial begin
    for (int d = 0; d < 2; d++) begin wq[d] = 0; rq[d] = 0; lg[d] = 0; end
    repeat (3) @(negedge clk);
    check(!wa[0] && ra[0] == 0 && !lq[0] && !wa[1] && ra[1] == 0 && !lq[1],
          "R10 reset state", {wa[0], ra[0], lq[0]}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    scen(1, 1, 1);
    scen(1, 0, 0);
    scen(0, 1, 0);
    scen(0, 0, 1);
    scen(0, 1, 1);
    scen(1, 1, 0);
    scen(1, 0, 1);
    begin : late
      int l0;
      l0 = lrise[0];
      exp0.push_back(3'b001); tag0.push_back("R9 early reader");
      exp0.push_back(3'b100); tag0.push_back("R9 late writer next cycle");
      @(negedge clk);
      rq[0] <= 2'b01;
      while (!ra[0][0]) @(negedge clk);
      wq[0] <= 1'b1;
      wait_idle();
      check(lrise[0] - l0 == 2, "R9 late request needs new lock cycle", lrise[0] - l0, 2);
    end
    begin : midreset
      exp0.push_back(3'b100); tag0.push_back("R10 writer before reset");
      @(negedge clk);
      wq[0] <= 1'b1;
      while (!wa[0]) @(negedge clk);
      #1 rst_n = 1'b0;
      #1 check(!wa[0] && ra[0] == 0 && !lq[0], "R10 reset clears outputs", {wa[0], lq[0]}, 0);
      @(negedge clk);
      wq[0] <= 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      wait_idle();
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) check(1'b0, "R7 watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule